// File: doc/BRIEF.md
# PCM Frame Timing Generator

This block derives every timing strobe needed by a 32-slot, 2.048 Mbit/s serial PCM bus from an 8.192 MHz system clock. It holds two independent frame counters, one for transmit and one for receive. Each side drives a 2.048 MHz bit clock, a one-slot-wide gate placed at a slot number set by a 5-bit code, and an 8 kHz frame sync. The transmit side also drives a 256 kHz line clock and a 2 kHz sync that marks a group of four frames.

The receive counter runs on its own clock pin. When that pin carries the system clock (local mode), the receive counter is cleared at the end of every four-frame transmit group, so the two sides stay locked without help. When the receive clock comes from an independent source (external mode), an align input clears both counters once through matched two-flop synchronisers, and the automatic clear is switched off. In local mode the align input has no effect.

The bit clocks and the slot gates are decoded from the counter and re-registered, so their edges are clean and mutually aligned. The line clock, the frame syncs and the group sync are taken straight from counter bits and so lead the registered strobes by one system clock. This block has no data interface; all pins are plain control and timing lines.

Top module: `pcm_frame_timer`

## Requirements
- R1: While rst_n is low, and at the first sample after it rises, every bit clock and slot gate is 0, the line clock is 0, and both frame syncs and the group sync are 1 (counter at zero).
- R2: Each bit clock has a period of 4 system clocks, high for 2 and low for 2.
- R3: Each slot gate is high for exactly 32 system clocks once per 1024-clock frame.
- R4: With slot code k (binary, 0 to 31), the slot gate rises 32*k+1 system clocks after the rising edge of the frame sync of the same side.
- R5: The frame sync has a 1024-clock period and is high for the first 512 clocks of each frame; the line clock has a 32-clock period; the group sync has a 4096-clock period and rises together with a frame sync rise.
- R6: The unregistered strobes lead the registered ones by one system clock: the bit clock rises one clock after each frame sync rise and one clock after each line clock rise.
- R7: In local mode (cfg_rx_ext = 0) a receive counter that has slipped is cleared at the end of the transmit four-frame group, so that the receive frame sync rises in the same cycle as the transmit group sync.
- R8: In local mode a pulse on align_btn leaves both counters running undisturbed: the transmit frame period stays 1024 clocks and the receive frame sync stays aligned with the transmit one.
- R9: In external mode (cfg_rx_ext = 1) a pulse on align_btn clears both counters, so that with equal clock rates the receive frame sync and slot gate then track the transmit ones cycle for cycle.
- R10: In external mode the four-frame automatic clear is disabled: a receive counter that has slipped stays slipped across a group boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | 8.192 MHz system clock, clocks the transmit counter |
| rx_clk | input | 1 | Receive counter clock; tie to clk_sys in local mode |
| rst_n | input | 1 | Asynchronous active-low reset for both counters |
| cfg_rx_ext | input | 1 | Static mode bit: 0 local receive clock, 1 external receive clock |
| align_btn | input | 1 | Align request, active high, effective in external mode only |
| tx_slot_sel | input | 5 | Transmit slot number, binary 0 to 31 |
| rx_slot_sel | input | 5 | Receive slot number, binary 0 to 31 |
| tx_bclk | output | 1 | Registered 2.048 MHz transmit bit clock |
| tx_slot_gate | output | 1 | Registered transmit slot gate |
| tx_fsync | output | 1 | 8 kHz transmit frame sync, straight from the counter |
| tx_lclk | output | 1 | 256 kHz transmit line clock, straight from the counter |
| tx_wsync | output | 1 | 2 kHz four-frame group sync, straight from the counter |
| rx_bclk | output | 1 | Registered 2.048 MHz receive bit clock |
| rx_slot_gate | output | 1 | Registered receive slot gate |
| rx_fsync | output | 1 | 8 kHz receive frame sync, straight from the counter |

## Verification
The assertions watch on every cycle the bit clock duty pattern, the exact slot gate width, the one-clock lag of the bit clock and of a slot-0 gate behind the frame sync, the coincidence of group and frame sync rises, and, in local mode, that the receive frame sync is high whenever a transmit group begins. Only the bench scenarios can show the slot position for non-zero codes, the absolute periods, the effect of a deliberately slipped receive clock before and after a group boundary, and the contrast between the align input being ignored in local mode and aligning both counters in external mode.

// File: rtl/pcm_timing_pkg.sv
`timescale 1ns/1ps
package pcm_timing_pkg;

  // Default split of the frame counter, least significant field first.
  localparam int DEF_PHASE_W = 2;  // system clocks per bit = 2**DEF_PHASE_W
  localparam int DEF_BIT_W   = 3;  // bits per slot         = 2**DEF_BIT_W
  localparam int DEF_SLOT_W  = 5;  // slots per frame       = 2**DEF_SLOT_W
  localparam int DEF_GROUP_W = 2;  // frames per group      = 2**DEF_GROUP_W

  typedef enum logic {
    RX_CLK_LOCAL    = 1'b0,
    RX_CLK_EXTERNAL = 1'b1
  } rx_clk_mode_e;

  function automatic int frame_cnt_width(input int phase_w, input int bit_w,
                                         input int slot_w, input int group_w);
    return phase_w + bit_w + slot_w + group_w;
  endfunction

endpackage

// File: rtl/pcm_level_sync.sv
`timescale 1ns/1ps
module pcm_level_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/pcm_slot_decode.sv
`timescale 1ns/1ps
module pcm_slot_decode #(
  parameter int SLOT_W = pcm_timing_pkg::DEF_SLOT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              phase_msb,
  input  logic [SLOT_W-1:0] slot_idx,
  input  logic [SLOT_W-1:0] sel,
  output logic              bclk_q,
  output logic              gate_q
);

  // Both strobes are decoded from the count and re-registered so that
  // they change on the same system clock edge with no decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_q <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      bclk_q <= ~phase_msb;
      gate_q <= (slot_idx == sel);
    end
  end

endmodule

// File: rtl/pcm_tx_timer.sv
`timescale 1ns/1ps
module pcm_tx_timer #(
  parameter int PHASE_W = pcm_timing_pkg::DEF_PHASE_W,
  parameter int BIT_W   = pcm_timing_pkg::DEF_BIT_W,
  parameter int SLOT_W  = pcm_timing_pkg::DEF_SLOT_W,
  parameter int GROUP_W = pcm_timing_pkg::DEF_GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SLOT_W-1:0] sel,
  output logic              bclk,
  output logic              gate,
  output logic              fsync,
  output logic              lclk,
  output logic              wsync,
  output logic              grp_last
);

  localparam int CNT_W   = pcm_timing_pkg::frame_cnt_width(PHASE_W, BIT_W, SLOT_W, GROUP_W);
  localparam int SLOT_LO = PHASE_W + BIT_W;
  localparam int LC_IDX  = PHASE_W + BIT_W - 1;
  localparam int FS_IDX  = CNT_W - GROUP_W - 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + CNT_W'(1);
  end

  // Straight counter taps, one clock ahead of the registered strobes.
  assign lclk     = cnt[LC_IDX];
  assign fsync    = ~cnt[FS_IDX];
  assign wsync    = ~cnt[CNT_W-1];
  assign grp_last = &cnt;

  pcm_slot_decode #(.SLOT_W(SLOT_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_msb (cnt[PHASE_W-1]),
    .slot_idx  (cnt[SLOT_LO +: SLOT_W]),
    .sel       (sel),
    .bclk_q    (bclk),
    .gate_q    (gate)
  );

endmodule

// File: rtl/pcm_rx_timer.sv
`timescale 1ns/1ps
module pcm_rx_timer #(
  parameter int PHASE_W = pcm_timing_pkg::DEF_PHASE_W,
  parameter int BIT_W   = pcm_timing_pkg::DEF_BIT_W,
  parameter int SLOT_W  = pcm_timing_pkg::DEF_SLOT_W,
  parameter int GROUP_W = pcm_timing_pkg::DEF_GROUP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SLOT_W-1:0] sel,
  output logic              bclk,
  output logic              gate,
  output logic              fsync
);

  localparam int CNT_W   = pcm_timing_pkg::frame_cnt_width(PHASE_W, BIT_W, SLOT_W, GROUP_W);
  localparam int SLOT_LO = PHASE_W + BIT_W;
  localparam int FS_IDX  = CNT_W - GROUP_W - 1;

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else          cnt <= cnt + CNT_W'(1);
  end

  assign fsync = ~cnt[FS_IDX];

  pcm_slot_decode #(.SLOT_W(SLOT_W)) u_dec (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase_msb (cnt[PHASE_W-1]),
    .slot_idx  (cnt[SLOT_LO +: SLOT_W]),
    .sel       (sel),
    .bclk_q    (bclk),
    .gate_q    (gate)
  );

endmodule

// File: rtl/pcm_frame_timer.sv
`timescale 1ns/1ps
module pcm_frame_timer #(
  parameter int PHASE_W     = pcm_timing_pkg::DEF_PHASE_W,
  parameter int BIT_W       = pcm_timing_pkg::DEF_BIT_W,
  parameter int SLOT_W      = pcm_timing_pkg::DEF_SLOT_W,
  parameter int GROUP_W     = pcm_timing_pkg::DEF_GROUP_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_sys,
  input  logic              rx_clk,
  input  logic              rst_n,
  input  logic              cfg_rx_ext,
  input  logic              align_btn,
  input  logic [SLOT_W-1:0] tx_slot_sel,
  input  logic [SLOT_W-1:0] rx_slot_sel,
  output logic              tx_bclk,
  output logic              tx_slot_gate,
  output logic              tx_fsync,
  output logic              tx_lclk,
  output logic              tx_wsync,
  output logic              rx_bclk,
  output logic              rx_slot_gate,
  output logic              rx_fsync
);

  import pcm_timing_pkg::*;

  rx_clk_mode_e rx_mode;
  logic         tx_btn_s, rx_btn_s;
  logic         tx_clr, rx_clr;
  logic         tx_grp_last;

  assign rx_mode = rx_clk_mode_e'(cfg_rx_ext);

  // Identical synchroniser depth on both sides keeps the two counters
  // released on corresponding edges when the clock rates match.
  pcm_level_sync #(.STAGES(SYNC_STAGES)) u_tx_btn_sync (
    .clk   (clk_sys),
    .rst_n (rst_n),
    .d     (align_btn),
    .q     (tx_btn_s)
  );

  pcm_level_sync #(.STAGES(SYNC_STAGES)) u_rx_btn_sync (
    .clk   (rx_clk),
    .rst_n (rst_n),
    .d     (align_btn),
    .q     (rx_btn_s)
  );

  always_comb begin
    tx_clr = 1'b0;
    rx_clr = tx_grp_last;
    if (rx_mode == RX_CLK_EXTERNAL) begin
      tx_clr = tx_btn_s;
      rx_clr = rx_btn_s;
    end
  end

  pcm_tx_timer #(
    .PHASE_W (PHASE_W),
    .BIT_W   (BIT_W),
    .SLOT_W  (SLOT_W),
    .GROUP_W (GROUP_W)
  ) u_tx (
    .clk      (clk_sys),
    .rst_n    (rst_n),
    .clr      (tx_clr),
    .sel      (tx_slot_sel),
    .bclk     (tx_bclk),
    .gate     (tx_slot_gate),
    .fsync    (tx_fsync),
    .lclk     (tx_lclk),
    .wsync    (tx_wsync),
    .grp_last (tx_grp_last)
  );

  pcm_rx_timer #(
    .PHASE_W (PHASE_W),
    .BIT_W   (BIT_W),
    .SLOT_W  (SLOT_W),
    .GROUP_W (GROUP_W)
  ) u_rx (
    .clk   (rx_clk),
    .rst_n (rst_n),
    .clr   (rx_clr),
    .sel   (rx_slot_sel),
    .bclk  (rx_bclk),
    .gate  (rx_slot_gate),
    .fsync (rx_fsync)
  );

endmodule

// File: rtl/pcm_frame_timer_chk.sv
`timescale 1ns/1ps
module pcm_frame_timer_chk #(
  parameter int PHASE_W = pcm_timing_pkg::DEF_PHASE_W,
  parameter int BIT_W   = pcm_timing_pkg::DEF_BIT_W,
  parameter int SLOT_W  = pcm_timing_pkg::DEF_SLOT_W
) (
  input logic              clk_sys,
  input logic              rst_n,
  input logic              cfg_rx_ext,
  input logic [SLOT_W-1:0] tx_slot_sel,
  input logic              tx_bclk,
  input logic              tx_slot_gate,
  input logic              tx_fsync,
  input logic              tx_wsync,
  input logic              rx_fsync
);

  localparam int RUN_W = PHASE_W + BIT_W + 1;
  localparam logic [RUN_W-1:0] GATE_LEN = RUN_W'(1 << (PHASE_W + BIT_W));

  logic [RUN_W-1:0] gate_run;

  always_ff @(posedge clk_sys or negedge rst_n) begin
    if (!rst_n)            gate_run <= '0;
    else if (tx_slot_gate) gate_run <= gate_run + RUN_W'(1);
    else                   gate_run <= '0;
  end

  // R2: bit clock stays high for two cycles after rising
  a_r2_bclk_high_two: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $rose(tx_bclk) |=> tx_bclk);

  // R2: bit clock stays low for two cycles after falling
  a_r2_bclk_low_two: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!cfg_rx_ext && $fell(tx_bclk)) |=> !tx_bclk);

  // R3: gate width is one full slot
  a_r3_gate_width: assert property (@(posedge clk_sys) disable iff (!rst_n)
    $fell(tx_slot_gate) |-> (gate_run == GATE_LEN));

  // R4: slot 0 gate opens one clock after the frame sync
  a_r4_slot0_after_fsync: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!cfg_rx_ext && $rose(tx_fsync) && (tx_slot_sel == '0)) |=> $rose(tx_slot_gate));

  // R5: group sync starts on a frame boundary
  a_r5_wsync_on_frame: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!cfg_rx_ext && $rose(tx_wsync)) |-> $rose(tx_fsync));

  // R6: registered bit clock lags the unregistered frame sync by one clock
  a_r6_bclk_lags_fsync: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!cfg_rx_ext && $rose(tx_fsync)) |=> $rose(tx_bclk));

  // R7: in local mode the receive frame starts with every transmit group
  a_r7_rx_group_resync: assert property (@(posedge clk_sys) disable iff (!rst_n)
    (!cfg_rx_ext && $rose(tx_wsync)) |-> rx_fsync);

endmodule

bind pcm_frame_timer pcm_frame_timer_chk #(
  .PHASE_W (PHASE_W),
  .BIT_W   (BIT_W),
  .SLOT_W  (SLOT_W)
) u_chk (.*);

// File: tb/pcm_frame_timer_bench.sv
`timescale 1ns/1ps
module pcm_frame_timer_bench;

  localparam int SIG_TX_FSYNC = 0;
  localparam int SIG_TX_GATE  = 1;
  localparam int SIG_TX_BCLK  = 2;
  localparam int SIG_TX_LCLK  = 3;
  localparam int SIG_TX_WSYNC = 4;
  localparam int SIG_RX_FSYNC = 5;
  localparam int SIG_RX_GATE  = 6;

  logic       clk, rx_clk, rst_n, cfg_rx_ext, align_btn, rx_hold;
  logic [4:0] tx_slot_sel, rx_slot_sel;
  logic       tx_bclk, tx_slot_gate, tx_fsync, tx_lclk, tx_wsync;
  logic       rx_bclk, rx_slot_gate, rx_fsync;
  logic       prev_rx_fsync;
  int         ph;
  int         n_chk = 0;
  int         n_fail = 0;

  pcm_frame_timer u_pcm_frame_timer (
    .clk_sys      (clk),
    .rx_clk       (rx_clk),
    .rst_n        (rst_n),
    .cfg_rx_ext   (cfg_rx_ext),
    .align_btn    (align_btn),
    .tx_slot_sel  (tx_slot_sel),
    .rx_slot_sel  (rx_slot_sel),
    .tx_bclk      (tx_bclk),
    .tx_slot_gate (tx_slot_gate),
    .tx_fsync     (tx_fsync),
    .tx_lclk      (tx_lclk),
    .tx_wsync     (tx_wsync),
    .rx_bclk      (rx_bclk),
    .rx_slot_gate (rx_slot_gate),
    .rx_fsync     (rx_fsync)
  );

  // 100 MHz system clock; the receive clock follows it in local mode and
  // runs 2 ns earlier in external mode. rx_hold freezes the receive clock.
  initial begin
    clk = 1'b0; rx_clk = 1'b0; ph = 0;
    forever begin
      #1;
      ph++;
      clk = ((ph / 5) % 2) == 1;
      if (!rx_hold) rx_clk = cfg_rx_ext ? (((ph + 2) / 5) % 2) == 1 : clk;
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not complete (actual timeout, expected completion)");
    finish_run();
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    prev_rx_fsync = rx_fsync;
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  function automatic logic sig(input int k);
    case (k)
      SIG_TX_FSYNC: return tx_fsync;
      SIG_TX_GATE:  return tx_slot_gate;
      SIG_TX_BCLK:  return tx_bclk;
      SIG_TX_LCLK:  return tx_lclk;
      SIG_TX_WSYNC: return tx_wsync;
      SIG_RX_FSYNC: return rx_fsync;
      SIG_RX_GATE:  return rx_slot_gate;
      default:      return 1'b0;
    endcase
  endfunction

  // Count samples until signal k makes the requested transition.
  task automatic wait_edge(input int k, input bit rising, output int n);
    logic p, c;
    bit   hit;
    p = sig(k); n = 0; hit = 0;
    while (!hit && n < 10000) begin
      tick();
      n++;
      c = sig(k);
      hit = rising ? (!p && c) : (p && !c);
      p = c;
    end
    if (!hit) check(1'b0, "edge timeout", n, 0);
  endtask

  task automatic t_reset_state();
    int n;
    rst_n = 1'b0; cfg_rx_ext = 1'b0; align_btn = 1'b0; rx_hold = 1'b0;
    tx_slot_sel = 5'd0; rx_slot_sel = 5'd0;
    ticks(4);
    rst_n = 1'b1;
    // R1: no clock edge yet since release
    check(tx_bclk == 1'b0 && rx_bclk == 1'b0, "R1 bit clocks low", tx_bclk + rx_bclk, 0);
    check(tx_slot_gate == 1'b0 && rx_slot_gate == 1'b0, "R1 gates low",
          tx_slot_gate + rx_slot_gate, 0);
    check(tx_lclk == 1'b0, "R1 line clock low", tx_lclk, 0);
    check(tx_fsync && rx_fsync && tx_wsync, "R1 syncs high",
          tx_fsync + rx_fsync + tx_wsync, 3);
    n = 0;
  endtask

  task automatic t_bit_clock();
    int n;
    wait_edge(SIG_TX_BCLK, 1'b1, n);
    tick(); check(tx_bclk == 1'b1, "R2 bclk high 2nd cycle", tx_bclk, 1);
    tick(); check(tx_bclk == 1'b0, "R2 bclk low 3rd cycle", tx_bclk, 0);
    tick(); check(tx_bclk == 1'b0, "R2 bclk low 4th cycle", tx_bclk, 0);
    tick(); check(tx_bclk == 1'b1, "R2 bclk high again", tx_bclk, 1);
  endtask

  task automatic t_sync_periods();
    int n;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    wait_edge(SIG_TX_FSYNC, 1'b0, n);
    check(n == 512, "R5 fsync high time", n, 512);
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(n == 512, "R5 fsync low time", n, 512);
    wait_edge(SIG_TX_LCLK, 1'b1, n);
    wait_edge(SIG_TX_LCLK, 1'b1, n);
    check(n == 32, "R5 line clock period", n, 32);
    wait_edge(SIG_TX_WSYNC, 1'b1, n);
    wait_edge(SIG_TX_WSYNC, 1'b1, n);
    check(n == 4096, "R5 group sync period", n, 4096);
  endtask

  task automatic t_lead();
    int n;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    wait_edge(SIG_TX_BCLK, 1'b1, n);
    check(n == 1, "R6 bclk after fsync", n, 1);
    wait_edge(SIG_TX_LCLK, 1'b1, n);
    wait_edge(SIG_TX_BCLK, 1'b1, n);
    check(n == 1, "R6 bclk after line clock", n, 1);
  endtask

  task automatic t_tx_slot(input int sel);
    int n;
    wait_edge(SIG_TX_FSYNC, 1'b0, n);  // mid-frame, slot 16
    tx_slot_sel = 5'(sel);
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    wait_edge(SIG_TX_GATE, 1'b1, n);
    check(n == 32 * sel + 1, "R4 tx gate position", n, 32 * sel + 1);
    wait_edge(SIG_TX_GATE, 1'b0, n);
    check(n == 32, "R3 tx gate width", n, 32);
    wait_edge(SIG_TX_GATE, 1'b1, n);
    check(n == 992, "R3 tx gate once per frame", n, 992);
  endtask

  task automatic t_rx_slot(input int sel);
    int n;
    wait_edge(SIG_RX_FSYNC, 1'b0, n);
    rx_slot_sel = 5'(sel);
    wait_edge(SIG_RX_FSYNC, 1'b1, n);
    wait_edge(SIG_RX_GATE, 1'b1, n);
    check(n == 32 * sel + 1, "R4 rx gate position", n, 32 * sel + 1);
    wait_edge(SIG_RX_GATE, 1'b0, n);
    check(n == 32, "R3 rx gate width", n, 32);
  endtask

  task automatic t_local_resync();
    int n;
    wait_edge(SIG_TX_WSYNC, 1'b1, n);
    ticks(50);
    rx_hold = 1'b1;
    ticks(100);
    rx_hold = 1'b0;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(rx_fsync == 1'b0, "R7 rx slipped before group end", rx_fsync, 0);
    wait_edge(SIG_TX_WSYNC, 1'b1, n);
    check(rx_fsync == 1'b1 && prev_rx_fsync == 1'b0, "R7 rx realigned at group end",
          rx_fsync, 1);
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(rx_fsync == 1'b1 && prev_rx_fsync == 1'b0, "R7 rx stays aligned", rx_fsync, 1);
  endtask

  task automatic t_local_btn_ignored();
    int n;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    ticks(300);
    align_btn = 1'b1;
    ticks(5);
    align_btn = 1'b0;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(n + 305 == 1024, "R8 tx frame period kept", n + 305, 1024);
    check(rx_fsync == 1'b1 && prev_rx_fsync == 1'b0, "R8 rx still aligned", rx_fsync, 1);
  endtask

  task automatic t_ext_no_auto();
    int n;
    cfg_rx_ext = 1'b1;
    wait_edge(SIG_TX_FSYNC, 1'b0, n);
    rx_hold = 1'b1;
    ticks(100);
    rx_hold = 1'b0;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(rx_fsync == 1'b0, "R10 rx slipped in external mode", rx_fsync, 0);
    wait_edge(SIG_TX_WSYNC, 1'b1, n);
    check(rx_fsync == 1'b0, "R10 no clear at group end", rx_fsync, 0);
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(rx_fsync == 1'b0, "R10 still slipped next frame", rx_fsync, 0);
  endtask

  task automatic t_ext_align();
    int n;
    wait_edge(SIG_TX_FSYNC, 1'b0, n);  // slot 16, away from slot 5
    rx_slot_sel = 5'd5;
    align_btn = 1'b1;
    ticks(4);
    align_btn = 1'b0;
    wait_edge(SIG_TX_FSYNC, 1'b1, n);
    check(rx_fsync == 1'b1 && prev_rx_fsync == 1'b0, "R9 rx fsync aligned after align",
          rx_fsync, 1);
    wait_edge(SIG_RX_GATE, 1'b1, n);
    check(n == 161 && tx_slot_gate == 1'b1, "R9 rx gate tracks tx gate", n, 161);
  endtask

  initial begin
    t_reset_state();
    t_bit_clock();
    t_sync_periods();
    t_lead();
    t_tx_slot(0);
    t_tx_slot(31);
    t_tx_slot(5);
    t_rx_slot(7);
    t_local_resync();
    t_local_btn_ignored();
    t_ext_no_auto();
    t_ext_align();
    finish_run();
  end

endmodule